// File: doc/BRIEF.md
# Multi-Mode ROM Bank Mapper

This block turns 16-bit processor addresses that fall into the main flash subslot of a cartridge into 23-bit flash addresses. One file of four 8-bit bank registers serves five banking schemes. These are a Konami scheme with a sound-chip bank map, a plain Konami scheme, an 8 KB-page ASCII scheme, a 16 KB-page ASCII scheme and a linear 64 KB scheme. A 10-bit offset is added to every bank number. This lets software reach the whole flash from one window. A disk-kernel mode redirects the first two 8 KB pages to a fixed pair of banks.

The block decodes its own control registers from bus writes: the mode register, the two halves of the offset and the configuration register. Each write is also offered to the flash. It uses the address the mapping produced before the write changed any register, and it goes through only when the configuration permits flash writes. The sound-chip register windows and the flash command protocol lie outside this block.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset the bank registers hold 0, 1, 2 and 3, the offset is 0, the mode register is 0 (sound-chip Konami scheme, no locks, no masking), flash writes are enabled and block protect is asserted.
- R2: A write to 0x7FFF loads the mode register. Data[7:6] selects the scheme: 00 Konami family, 01 linear 64 KB, 10 ASCII 8 KB, 11 ASCII 16 KB. Within the Konami family, data[5]=1 selects plain Konami. Once bit 2 is set, further writes to 0x7FFF are ignored.
- R3: In the sound-chip Konami scheme, a write in 0x4000–0xBFFF with addr[12:11]=2'b10 loads the bank register of page addr[15:13]-2. With mode bit 0 set, the value is masked to 0x3F when it is stored.
- R4: In plain Konami, a write in 0x5000–0x57FF or 0x6000–0xBFFF loads the register of page addr[15:13]-2, and writes in 0x4000–0x4FFF and 0x5800–0x5FFF change no bank. Mode bit 3 blocks every write to page 0. Mode bit 0 masks stored values to 0x1F.
- R5: In the ASCII 8 KB scheme, only writes in 0x6000–0x7FFF change banks, and addr[12:11] selects the register.
- R6: In the ASCII 16 KB scheme, a write of v in 0x6000–0x67FF sets registers 0 and 1 to 2v and 2v+1, and a write in 0x7000–0x77FF does the same for registers 2 and 3. Results are kept to 8 bits.
- R7: In the linear 64 KB scheme, every address is mapped. The page is addr[15:14] and pages are 16 KB. A write in 0x4000–0xBFFF loads register addr[15:13]-2 with the unmasked value.
- R8: A write to 0x7FFD sets offset[7:0], and a write to 0x7FFE sets offset[9:8] from data[1:0]. The offset is added to the bank number modulo 1024. While mode bit 1 is set, the bank and offset registers ignore all writes.
- R9: The flash address is (bank × page size + in-page offset + 0x10000) modulo 2^23. In the three 8 KB schemes, pages 0–3 cover 0x4000–0xBFFF and any address outside that range is reported unmapped.
- R10: With the disk-kernel bit set (configuration bit 4), page 0 with register 0 holding 0 maps to bank 0x3FA, and page 1 with register 1 holding 1 maps to bank 0x3FB. The offset is not added in either case.
- R11: A write to 0x7FFC loads the configuration register. Bit 0 enables flash writes, bit 1 drives block_protect_o, bit 4 enables disk-kernel mode, and bit 7 makes the register ignore all later writes.
- R12: flash_we_o is wr_i AND mapped AND the flash-write-enable bit. Both the address and this enable come from the register state before the current write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address within the subslot |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| flash_addr_o | output | 23 | Translated flash byte address |
| mapped_o | output | 1 | Address falls in a mapped window |
| flash_we_o | output | 1 | Forward this write to the flash |
| block_protect_o | output | 1 | Flash block protect level |

## Verification
The hardest situations to reach are those where a single control write also hits a bank window. For example, 0x7FFF lies inside the ASCII 8 KB bank range, so changing scheme from there also loads register 3, and plain Konami loads register 1. The disk-kernel remap needs registers 0 and 1 to hold exactly 0 and 1 while a non-zero offset is active. The stimulus runs one long scripted sequence through every scheme in turn, and each expected address is recomputed from the register history, side loads included. The lock bits are then exercised last, so that a blocked write can be told apart from a write that merely stored the same value.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int BUS_AW = 16;
  localparam int BUS_DW = 8;
  localparam int NBANK  = 4;

  localparam logic [BUS_AW-1:0] A_CFG    = 16'h7FFC;
  localparam logic [BUS_AW-1:0] A_OFF_LO = 16'h7FFD;
  localparam logic [BUS_AW-1:0] A_OFF_HI = 16'h7FFE;
  localparam logic [BUS_AW-1:0] A_MODE   = 16'h7FFF;

  typedef enum logic [2:0] {
    MAP_KSCC, MAP_KONAMI, MAP_LIN64, MAP_ASC8, MAP_ASC16
  } map_mode_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       kon_plain;
    logic       pg0_lock;
    logic       mode_lock;
    logic       bank_lock;
    logic       mask_en;
  } mode_t;

  typedef struct packed {
    logic lock;
    logic dsk;
    logic prot;
    logic we;
  } cfg_t;

  function automatic map_mode_e decode_mode(mode_t m);
    unique case (m.sel)
      2'b00:   return m.kon_plain ? MAP_KONAMI : MAP_KSCC;
      2'b01:   return MAP_LIN64;
      2'b10:   return MAP_ASC8;
      default: return MAP_ASC16;
    endcase
  endfunction
endpackage

// File: rtl/mapper_ctrl_regs.sv
module mapper_ctrl_regs
  import mapper_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic              wr_i,
  output mode_t             mode_o,
  output cfg_t              cfg_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int OFF_HI = OFF_W - 8;

  mode_t            mode_q;
  cfg_t             cfg_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cfg_q  <= '{lock: 1'b0, dsk: 1'b0, prot: 1'b1, we: 1'b1};
      off_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_CFG && !cfg_q.lock)
        cfg_q <= '{lock: wdata_i[7], dsk: wdata_i[4], prot: wdata_i[1], we: wdata_i[0]};
      if (addr_i == A_MODE && !mode_q.mode_lock)
        mode_q <= {wdata_i[7:5], wdata_i[3:0]};
      if (!mode_q.bank_lock) begin
        if (addr_i == A_OFF_LO) off_q[7:0] <= wdata_i;
        if (addr_i == A_OFF_HI) off_q[OFF_W-1:8] <= wdata_i[OFF_HI-1:0];
      end
    end
  end

  assign mode_o = mode_q;
  assign cfg_o  = cfg_q;
  assign off_o  = off_q;
endmodule

// File: rtl/mapper_bank_file.sv
module mapper_bank_file
  import mapper_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [BUS_AW-1:0]           addr_i,
  input  logic [BUS_DW-1:0]           wdata_i,
  input  logic                        wr_i,
  input  mode_t                       mode_i,
  output logic [NBANK-1:0][BUS_DW-1:0] bank_o
);
  map_mode_e  mode;
  logic [2:0] pg3;
  logic       win;
  logic       asc8_win, asc16_lo, asc16_hi;
  logic       kon_skip;

  assign mode     = decode_mode(mode_i);
  assign pg3      = addr_i[15:13] - 3'd2;
  assign win      = !pg3[2];
  assign asc8_win = addr_i[15:13] == 3'b011;
  assign asc16_lo = addr_i[15:11] == 5'b01100;
  assign asc16_hi = addr_i[15:11] == 5'b01110;
  // plain Konami: only the 0x5000-0x57FF slice of page 0 switches, and bit 3 blocks page 0
  assign kon_skip = (pg3[1:0] == 2'd0) && (mode_i.pg0_lock || addr_i[12:11] != 2'b10);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic              ld;
    logic [BUS_DW-1:0] nxt;
    logic [BUS_DW-1:0] q;

    always_comb begin
      ld  = 1'b0;
      nxt = wdata_i;
      unique case (mode)
        MAP_KSCC: begin
          ld  = win && addr_i[12:11] == 2'b10 && pg3[1:0] == 2'(i);
          nxt = mode_i.mask_en ? (wdata_i & 8'h3F) : wdata_i;
        end
        MAP_KONAMI: begin
          ld  = win && pg3[1:0] == 2'(i) && !kon_skip;
          nxt = mode_i.mask_en ? (wdata_i & 8'h1F) : wdata_i;
        end
        MAP_LIN64: ld = win && pg3[1:0] == 2'(i);
        MAP_ASC8:  ld = asc8_win && addr_i[12:11] == 2'(i);
        default: begin
          ld  = (i < 2) ? asc16_lo : asc16_hi;
          nxt = {wdata_i[6:0], 1'(i % 2)};
        end
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= BUS_DW'(i);
      else if (wr_i && !mode_i.bank_lock && ld) q <= nxt;
    end

    assign bank_o[i] = q;
  end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int                FLASH_AW   = 23,
  parameter int                OFF_W      = 10,
  parameter logic [FLASH_AW-1:0] FLASH_BASE = 23'h010000,
  parameter logic [OFF_W-1:0]  DSK_BANK0  = 10'h3FA,
  parameter logic [OFF_W-1:0]  DSK_BANK1  = 10'h3FB
) (
  input  logic [BUS_AW-1:0]            addr_i,
  input  mode_t                        mode_i,
  input  logic                         dsk_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic [NBANK-1:0][BUS_DW-1:0] bank_i,
  output logic [FLASH_AW-1:0]          flash_addr_o,
  output logic                         mapped_o
);
  localparam int SUM_W = OFF_W + 14;

  logic              lin;
  logic [2:0]        pg3;
  logic [1:0]        pg;
  logic [BUS_DW-1:0] raw;
  logic [OFF_W-1:0]  eff;
  logic [SUM_W-1:0]  lin_addr, sum;

  assign lin      = decode_mode(mode_i) == MAP_LIN64;
  assign pg3      = addr_i[15:13] - 3'd2;
  assign mapped_o = lin || !pg3[2];
  assign pg       = lin ? addr_i[15:14] : pg3[1:0];
  assign raw      = bank_i[pg];

  always_comb begin
    if (dsk_i && pg == 2'd0 && raw == 8'd0)      eff = DSK_BANK0;
    else if (dsk_i && pg == 2'd1 && raw == 8'd1) eff = DSK_BANK1;
    else                                         eff = OFF_W'(raw) + off_i;
  end

  assign lin_addr     = lin ? {eff, addr_i[13:0]} : {1'b0, eff, addr_i[12:0]};
  assign sum          = lin_addr + SUM_W'(FLASH_BASE);
  assign flash_addr_o = FLASH_AW'(sum);
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import mapper_pkg::*;
#(
  parameter int                  FLASH_AW   = 23,
  parameter int                  OFF_W      = 10,
  parameter logic [FLASH_AW-1:0] FLASH_BASE = 23'h010000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                wr_i,
  output logic [FLASH_AW-1:0] flash_addr_o,
  output logic                mapped_o,
  output logic                flash_we_o,
  output logic                block_protect_o
);
  mode_t                        mode_q;
  cfg_t                         cfg_q;
  logic [OFF_W-1:0]             off_q;
  logic [NBANK-1:0][BUS_DW-1:0] bank_q;

  mapper_ctrl_regs #(.OFF_W(OFF_W)) i_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i,
    .mode_o(mode_q), .cfg_o(cfg_q), .off_o(off_q)
  );

  mapper_bank_file i_banks (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i,
    .mode_i(mode_q), .bank_o(bank_q)
  );

  mapper_xlate #(
    .FLASH_AW(FLASH_AW), .OFF_W(OFF_W), .FLASH_BASE(FLASH_BASE),
    .DSK_BANK0(OFF_W'(10'h3FA)), .DSK_BANK1(OFF_W'(10'h3FB))
  ) i_xlate (
    .addr_i, .mode_i(mode_q), .dsk_i(cfg_q.dsk), .off_i(off_q), .bank_i(bank_q),
    .flash_addr_o, .mapped_o
  );

  // registers update at the edge, so address and enable reflect pre-write state
  assign flash_we_o      = wr_i && mapped_o && cfg_q.we;
  assign block_protect_o = cfg_q.prot;
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker
  import mapper_pkg::*;
#(
  parameter int FLASH_AW = 23,
  parameter int OFF_W    = 10
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [15:0]                  addr_i,
  input logic                         wr_i,
  input logic [FLASH_AW-1:0]          flash_addr_o,
  input logic                         mapped_o,
  input logic                         flash_we_o,
  input mode_t                        mode_q,
  input cfg_t                         cfg_q,
  input logic [OFF_W-1:0]             off_q,
  input logic [NBANK-1:0][BUS_DW-1:0] bank_q
);
  p_we_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> (wr_i && mapped_o));

  p_mode_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MODE && mode_q.mode_lock) |=> $stable(mode_q));

  p_cfg_lock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> $stable(cfg_q));

  p_bank_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.bank_lock |=> ($stable(bank_q) && $stable(off_q)));

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.sel != 2'b01 && (addr_i[15:14] == 2'b00 || addr_i[15:14] == 2'b11)) |-> !mapped_o);

  p_dsk_remap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.dsk && mode_q.sel != 2'b01 && addr_i[15:13] == 3'b010 && bank_q[0] == 8'd0)
      |-> flash_addr_o == FLASH_AW'({11'h002, addr_i[12:0]} << 1 >> 1));
endmodule

bind rom_bank_mapper mapper_checker #(.FLASH_AW(FLASH_AW), .OFF_W(OFF_W)) i_mapper_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .flash_addr_o(flash_addr_o), .mapped_o(mapped_o), .flash_we_o(flash_we_o),
  .mode_q(mode_q), .cfg_q(cfg_q), .off_q(off_q), .bank_q(bank_q)
);

// File: tb/test_rom_bank_mapper.sv
module test_rom_bank_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic [22:0] flash_addr_o;
  logic        mapped_o, flash_we_o, block_protect_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rom_bank_mapper i_rom_bank_mapper (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i,
    .flash_addr_o, .mapped_o, .flash_we_o, .block_protect_o
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic peek(string req, logic [15:0] a, logic [22:0] exp);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0;
    #2;
    chk({req, " mapped"}, int'(mapped_o), 1);
    chk({req, " addr"}, int'(flash_addr_o), int'(exp));
  endtask

  task automatic unmapped(string req, logic [15:0] a);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0;
    #2;
    chk({req, " unmapped"}, int'(mapped_o), 0);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wr_we(string req, logic [15:0] a, logic [7:0] d, bit exp_we);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    #2;
    chk({req, " flash_we"}, int'(flash_we_o), int'(exp_we));
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic t_reset;
    peek("R1", 16'h4000, 23'h010000);
    peek("R1", 16'h6000, 23'h012000);
    peek("R1", 16'h8000, 23'h014000);
    peek("R9", 16'hA123, 23'h016123);
    unmapped("R9", 16'h0000);
    unmapped("R9", 16'hC000);
    chk("R1 protect", int'(block_protect_o), 1);
    wr_we("R12 unmapped", 16'hC000, 8'h00, 1'b0);
  endtask

  task automatic t_kscc;
    @(negedge clk_i);
    addr_i = 16'h9000; wdata_i = 8'h45; wr_i = 1'b1;
    #2;
    chk("R12 pre-write addr", int'(flash_addr_o), 'h015000);
    chk("R12 we", int'(flash_we_o), 1);
    @(negedge clk_i);
    wr_i = 1'b0;
    peek("R3", 16'h9000, 23'h09B000);
    peek("R3", 16'h8010, 23'h09A010);
    wr(16'h8000, 8'h07);
    peek("R3 no-load", 16'h8010, 23'h09A010);
    wr(16'h7FFF, 8'h01);
    wr(16'h9000, 8'hFF);
    peek("R3 mask", 16'h8000, 23'h08E000);
  endtask

  task automatic t_konami;
    wr(16'h7FFF, 8'h21);
    wr(16'h4000, 8'h09);
    peek("R4 ignore 4000", 16'h4000, 23'h010000);
    wr(16'h5000, 8'hFF);
    peek("R4 mask", 16'h4000, 23'h04E000);
    wr(16'h5800, 8'h05);
    peek("R4 ignore 5800", 16'h4000, 23'h04E000);
    wr(16'h7FFF, 8'h28);
    wr(16'h5000, 8'h04);
    peek("R4 page0 lock", 16'h4000, 23'h04E000);
    wr(16'h6000, 8'h80);
    peek("R4 page1", 16'h6000, 23'h110000);
  endtask

  task automatic t_asc8;
    wr(16'h7FFF, 8'h80);
    wr(16'h6800, 8'h11);
    peek("R5 reg1", 16'h6000, 23'h032000);
    wr(16'h7800, 8'h22);
    peek("R5 reg3", 16'hA000, 23'h054000);
    wr(16'h4000, 8'h33);
    peek("R5 ignore", 16'h4000, 23'h04E000);
  endtask

  task automatic t_asc16;
    wr(16'h7FFF, 8'hC0);
    wr(16'h6000, 8'h05);
    peek("R6 lo even", 16'h4000, 23'h024000);
    peek("R6 lo odd", 16'h6000, 23'h026000);
    wr(16'h7000, 8'h81);
    peek("R6 hi even", 16'h8000, 23'h014000);
    peek("R6 hi odd", 16'hA000, 23'h016000);
    wr(16'h6800, 8'h77);
    peek("R6 ignore", 16'h4000, 23'h024000);
  endtask

  task automatic t_offset;
    wr(16'h7FFD, 8'h10);
    peek("R8 low", 16'h4000, 23'h044000);
    wr(16'h7FFE, 8'h03);
    peek("R8 high", 16'h4000, 23'h644000);
    wr(16'h7FFD, 8'hEE);
    peek("R9 wrap 8MB", 16'h4000, 23'h000000);
    peek("R9 wrap 8MB", 16'h4001, 23'h000001);
    wr(16'h7FFD, 8'hFF);
    peek("R8 mod 1024", 16'h4000, 23'h022000);
    wr(16'h7FFE, 8'h00);
    wr(16'h7FFD, 8'h00);
    peek("R8 clear", 16'h4000, 23'h024000);
  endtask

  task automatic t_lin64;
    wr(16'h7FFF, 8'h40);
    peek("R7 page0", 16'h0000, 23'h038000);
    peek("R7 page3", 16'hC005, 23'h01C005);
    peek("R7 page1", 16'h4000, 23'h03C000);
    wr(16'h4000, 8'h07);
    peek("R7 load", 16'h0000, 23'h02C000);
    wr_we("R7 low write", 16'h0000, 8'h09, 1'b1);
    peek("R7 no-load", 16'h0000, 23'h02C000);
  endtask

  task automatic t_dsk;
    wr(16'h7FFF, 8'h80);
    wr(16'h6000, 8'h00);
    wr(16'h6800, 8'h01);
    wr(16'h7FFD, 8'h05);
    wr(16'h7FFC, 8'h13);
    peek("R10 bank0", 16'h4000, 23'h004000);
    peek("R10 bank1", 16'h6010, 23'h006010);
    peek("R10 other", 16'h8000, 23'h01E000);
    wr(16'h6000, 8'h02);
    peek("R10 not 0", 16'h4000, 23'h01E000);
    chk("R11 protect", int'(block_protect_o), 1);
  endtask

  task automatic t_cfg;
    wr_we("R12 old enable", 16'h7FFC, 8'h00, 1'b1);
    chk("R11 protect off", int'(block_protect_o), 0);
    wr_we("R11 we off", 16'h4000, 8'h00, 1'b0);
    peek("R11 dsk off", 16'h6000, 23'h01C000);
    wr(16'h7FFC, 8'h80);
    wr(16'h7FFC, 8'h03);
    wr_we("R11 locked", 16'h4000, 8'h00, 1'b0);
    chk("R11 locked protect", int'(block_protect_o), 0);
  endtask

  task automatic t_locks;
    wr(16'h7FFF, 8'h82);
    wr(16'h6000, 8'h55);
    peek("R8 bank lock", 16'h4000, 23'h01E000);
    wr(16'h7FFD, 8'h00);
    peek("R8 offset lock", 16'h4000, 23'h01E000);
    wr(16'h7FFF, 8'h84);
    wr(16'h6000, 8'h01);
    peek("R8 unlock", 16'h4000, 23'h01C000);
    wr(16'h7FFF, 8'hC0);
    wr(16'h6800, 8'h00);
    peek("R2 mode lock", 16'h6000, 23'h01A000);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_kscc();
    t_konami();
    t_asc8();
    t_asc16();
    t_offset();
    t_lin64();
    t_dsk();
    t_cfg();
    t_locks();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule